// File: doc/BRIEF.md
# Push-Button Click Classifier

This block watches a button level that has already been synchronized and debounced. On a request it sorts one press into four outcomes: no click, single click, double click or hold. Time is kept by a free-running tick counter. A prescaler advances the counter once every 2^`PRE_LOG2` system clocks, which is 1024 clocks by default and gives 46.875 kHz from 48 MHz. The hold limit in ticks is derived from a millisecond input as (`CLK_KHZ` × ms) >> `PRE_LOG2`. A zero millisecond input selects `DEFAULT_MS`.

In click mode, a release before the hold limit restarts the time base and opens a release window of `DBL_MS` milliseconds, converted the same way. A second press inside that window is a double click. A window that runs out is a single click. In held-only mode, a release before the limit reports a single click at once, and reaching the limit reports a hold.

A timeout is detected only when the tick count equals the start count plus the limit, modulo 2^`TICK_W`. Each finished evaluation presents a 3-bit code with a one-cycle valid strobe. A busy flag is high for the whole evaluation.

Top module: `btn_click_classifier`

## Requirements
- R1: After reset, `busy_o` and `result_valid_o` are low.
- R2: A request (`req_i`=1) taken while idle with `btn_i`=0 gives `result_valid_o`=1 with `result_o`=0 (no click) on the next cycle, and `busy_o` stays low.
- R3: In click mode (`held_only_i`=0), a press held until the tick counter equals the start tick plus ((`CLK_KHZ`×ms)>>`PRE_LOG2`) mod 2^`TICK_W` gives `result_o`=3 (hold).
- R4: A `hold_ms_i` of 0 uses `DEFAULT_MS` in place of the input when the limit is computed.
- R5: In click mode, a release restarts the start tick and sets the limit to (`CLK_KHZ`×`DBL_MS`)>>`PRE_LOG2`. If the button stays released until that limit is reached, `result_o`=1 (single click).
- R6: In click mode, a new press while the release window is open gives `result_o`=2 (double click).
- R7: In held-only mode (`held_only_i`=1), a release before the limit gives `result_o`=1, and reaching the limit while still pressed gives `result_o`=3.
- R8: `result_valid_o` lasts exactly one cycle. `busy_o` rises on the cycle after an accepted pressed-button request and falls on the cycle `result_valid_o` rises. The two are never high together. An illegal internal state reports `result_o`=7 (error).
- R9: A request that arrives while `busy_o` is high is ignored: the mode, limit and start tick of the running evaluation are unchanged, and no no-click result appears.
- R10: The tick counter is `TICK_W` bits wide and wraps. It advances by one exactly once every 2^`PRE_LOG2` clocks. Timeouts are found by equality modulo 2^`TICK_W`, so limits above 2^`TICK_W` are truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a classification (taken only while idle) |
| held_only_i | input | 1 | 1 = held-only mode, 0 = click mode; sampled with the request |
| hold_ms_i | input | MS_W | Hold limit in milliseconds, 0 = default; sampled with the request |
| btn_i | input | 1 | Debounced button level, 1 = pressed |
| busy_o | output | 1 | Evaluation in progress |
| result_valid_o | output | 1 | One-cycle strobe for `result_o` |
| result_o | output | 3 | 0 none, 1 single, 2 double, 3 hold, 7 error |

## Verification
The assertions check these properties on every cycle:
- Strobe and busy framing: exclusion, and busy falling only with a strobe.
- An immediate no-click answer to an idle request with the button released.
- The absence of no-click results while busy.
- The tick counter holding between prescaler pulses and stepping by one, with wrap, on each pulse.

Other behaviours need the bench's scenarios and its cycle-level reference model:
- Which code a press sequence yields, and in which cycle.
- The millisecond-to-tick conversion, including the zero default and truncation past the counter width.
- The restart of the time base on release.
- That a request made while busy leaves the running limit alone.

// File: rtl/click_cls_pkg.sv
package click_cls_pkg;

  typedef enum logic [2:0] {
    CODE_NONE   = 3'd0,
    CODE_SINGLE = 3'd1,
    CODE_DOUBLE = 3'd2,
    CODE_HOLD   = 3'd3,
    CODE_ERROR  = 3'd7
  } click_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HELD = 2'd1,
    ST_GAP  = 2'd2
  } click_state_e;

  // Ticks for a duration in ms: (clock in kHz * ms) scaled down by the prescaler.
  function automatic logic [63:0] ms_to_ticks(input int unsigned khz,
                                               input int unsigned pre_log2,
                                               input logic [31:0] ms);
    logic [63:0] prod;
    prod = 64'(khz) * 64'(ms);
    return prod >> pre_log2;
  endfunction

endpackage

// File: rtl/click_tick_base.sv
module click_tick_base #(
  parameter int unsigned PRE_LOG2 = 10,
  parameter int unsigned TICK_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick_pulse,
  output logic [TICK_W-1:0] tick_cnt
);
  logic [PRE_LOG2-1:0] pre_q;

  assign tick_pulse = (pre_q == {PRE_LOG2{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      tick_cnt <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick_pulse) tick_cnt <= tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/click_fsm.sv
module click_fsm
  import click_cls_pkg::*;
#(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              held_only_i,
  input  logic              btn_i,
  input  logic [TICK_W-1:0] tick_cnt,
  input  logic [TICK_W-1:0] hold_lim,
  input  logic [TICK_W-1:0] gap_lim,
  output logic              busy,
  output logic              expired,
  output logic              valid,
  output logic [2:0]        code
);
  click_state_e      state_q;
  logic              mode_q;
  logic [TICK_W-1:0] start_q;
  logic [TICK_W-1:0] lim_q;
  logic [TICK_W-1:0] due;

  assign due     = start_q + lim_q;
  assign expired = (tick_cnt == due);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      start_q <= '0;
      lim_q   <= '0;
      valid   <= 1'b0;
      code    <= CODE_NONE;
    end else begin
      valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (!btn_i) begin
              valid <= 1'b1;
              code  <= CODE_NONE;
            end else begin
              state_q <= ST_HELD;
              mode_q  <= held_only_i;
              start_q <= tick_cnt;
              lim_q   <= hold_lim;
            end
          end
        end
        ST_HELD: begin
          if (!btn_i) begin
            if (mode_q) begin
              valid   <= 1'b1;
              code    <= CODE_SINGLE;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_GAP;
              start_q <= tick_cnt;
              lim_q   <= gap_lim;
            end
          end else if (expired) begin
            valid   <= 1'b1;
            code    <= CODE_HOLD;
            state_q <= ST_IDLE;
          end
        end
        ST_GAP: begin
          if (btn_i) begin
            valid   <= 1'b1;
            code    <= CODE_DOUBLE;
            state_q <= ST_IDLE;
          end else if (expired) begin
            valid   <= 1'b1;
            code    <= CODE_SINGLE;
            state_q <= ST_IDLE;
          end
        end
        default: begin
          valid   <= 1'b1;
          code    <= CODE_ERROR;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/btn_click_classifier.sv
module btn_click_classifier
  import click_cls_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 48000,
  parameter int unsigned PRE_LOG2   = 10,
  parameter int unsigned TICK_W     = 16,
  parameter int unsigned MS_W       = 16,
  parameter int unsigned DEFAULT_MS = 1000,
  parameter int unsigned DBL_MS     = 500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            held_only_i,
  input  logic [MS_W-1:0] hold_ms_i,
  input  logic            btn_i,
  output logic            busy_o,
  output logic            result_valid_o,
  output logic [2:0]      result_o
);
  localparam logic [63:0] GAP_FULL = ms_to_ticks(CLK_KHZ, PRE_LOG2, 32'(DBL_MS));
  localparam logic [TICK_W-1:0] GAP_LIM = GAP_FULL[TICK_W-1:0];

  logic              tick_pulse;
  logic [TICK_W-1:0] tick_cnt;
  logic              expired;
  logic [31:0]       eff_ms;
  logic [63:0]       hold_full;
  logic [TICK_W-1:0] hold_lim;

  assign eff_ms    = (hold_ms_i == '0) ? 32'(DEFAULT_MS) : 32'(hold_ms_i);
  assign hold_full = ms_to_ticks(CLK_KHZ, PRE_LOG2, eff_ms);
  assign hold_lim  = hold_full[TICK_W-1:0];

  click_tick_base #(.PRE_LOG2(PRE_LOG2), .TICK_W(TICK_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_pulse(tick_pulse),
    .tick_cnt  (tick_cnt)
  );

  click_fsm #(.TICK_W(TICK_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .held_only_i(held_only_i),
    .btn_i      (btn_i),
    .tick_cnt   (tick_cnt),
    .hold_lim   (hold_lim),
    .gap_lim    (GAP_LIM),
    .busy       (busy_o),
    .expired    (expired),
    .valid      (result_valid_o),
    .code       (result_o)
  );
endmodule

// File: rtl/click_classifier_chk.sv
module click_classifier_chk #(
  parameter int unsigned TICK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              btn_i,
  input logic              busy_o,
  input logic              result_valid_o,
  input logic [2:0]        result_o,
  input logic              tick_pulse,
  input logic [TICK_W-1:0] tick_cnt
);
  AST_IDLE_NOCLICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i && !btn_i) |=> (result_valid_o && result_o == 3'd0 && !busy_o)); // R2

  AST_BUSY_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !result_valid_o); // R8

  AST_BUSY_ENDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> result_valid_o); // R8

  AST_BUSY_NO_NOCLICK: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !(result_valid_o && result_o == 3'd0)); // R9

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_pulse |=> $stable(tick_cnt)); // R10

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> (tick_cnt == TICK_W'($past(tick_cnt) + 1'b1))); // R10
endmodule

bind btn_click_classifier click_classifier_chk #(.TICK_W(TICK_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .btn_i         (btn_i),
  .busy_o        (busy_o),
  .result_valid_o(result_valid_o),
  .result_o      (result_o),
  .tick_pulse    (tick_pulse),
  .tick_cnt      (tick_cnt)
);

// File: tb/test_btn_click_classifier.sv
`timescale 1ns/1ps
module test_btn_click_classifier;
  localparam int KHZ = 48, PL = 2, TW = 8, DEF_MS = 10, GAP_MS = 5;
  localparam int DIV = 1 << PL;
  localparam int WRAP = 1 << TW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, hold_only = 1'b0, btn = 1'b0;
  logic [15:0] ms = 16'd3;
  logic busy, vld;
  logic [2:0] res;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  btn_click_classifier #(.CLK_KHZ(KHZ), .PRE_LOG2(PL), .TICK_W(TW), .MS_W(16),
                         .DEFAULT_MS(DEF_MS), .DBL_MS(GAP_MS)) i_btn_click_classifier (
    .clk(clk), .rst_n(rst_n), .req_i(req), .held_only_i(hold_only), .hold_ms_i(ms),
    .btn_i(btn), .busy_o(busy), .result_valid_o(vld), .result_o(res));

  function automatic int lim_of(input int m);
    return ((KHZ * m) / DIV) % WRAP;
  endfunction

  // behavioural reference: phase 0 idle, 1 pressed, 2 waiting after release
  int m_clk, m_phase, m_from, m_len;
  bit m_hmode, m_v;
  int m_code;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_clk = 0; m_phase = 0; m_v = 0; m_code = 0;
      m_from = 0; m_len = 0; m_hmode = 0;
    end else begin
      int now;
      bit due;
      now = (m_clk / DIV) % WRAP;
      due = (now == (m_from + m_len) % WRAP);
      m_v = 0;
      if (m_phase == 0) begin
        if (req && !btn) begin m_v = 1; m_code = 0; end
        else if (req) begin
          m_phase = 1; m_hmode = hold_only; m_from = now;
          m_len = lim_of(ms == 0 ? DEF_MS : int'(ms));
        end
      end else if (m_phase == 1) begin
        if (!btn && m_hmode) begin m_v = 1; m_code = 1; m_phase = 0; end
        else if (!btn) begin m_phase = 2; m_from = now; m_len = lim_of(GAP_MS); end
        else if (due) begin m_v = 1; m_code = 3; m_phase = 0; end
      end else begin
        if (btn) begin m_v = 1; m_code = 2; m_phase = 0; end
        else if (due) begin m_v = 1; m_code = 1; m_phase = 0; end
      end
      m_clk++;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (busy !== (m_phase != 0) || vld !== m_v || (m_v && res !== 3'(m_code))) begin
        fails++;
        $display("FAIL %s R8 model: busy=%0b valid=%0b code=%0d expected busy=%0b valid=%0b code=%0d",
                 tag, busy, vld, res, (m_phase != 0), m_v, m_code);
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string r, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    req = 1'b1; step(1); req = 1'b0;
  endtask

  task automatic wait_res(output int code, output int cyc);
    cyc = 0;
    while (!vld && cyc < 3000) begin step(1); cyc++; end
    code = int'(res);
    step(1);
    chk("R8 strobe width", vld == 1'b0, int'(vld), 0);
  endtask

  int c, n;
  initial begin
    step(4);
    chk("R1 busy after reset", busy == 1'b0, int'(busy), 0);
    chk("R1 valid after reset", vld == 1'b0, int'(vld), 0);
    rst_n = 1'b1; step(3);

    // R2: released button
    tag = "R2"; btn = 0; pulse_req();
    chk("R2 strobe next cycle", vld == 1'b1, int'(vld), 1);
    chk("R2 code none", res == 3'd0, int'(res), 0);
    chk("R2 busy stays low", busy == 1'b0, int'(busy), 0);
    step(5);

    // R3: hold with 3 ms -> 36 ticks
    tag = "R3"; btn = 1; ms = 3; hold_only = 0; step(2); pulse_req();
    chk("R8 busy rises", busy == 1'b1, int'(busy), 1);
    wait_res(c, n);
    chk("R3 hold code", c == 3, c, 3);
    chk("R3 hold timing", n >= (lim_of(3)-1)*DIV && n <= lim_of(3)*DIV+3, n, lim_of(3)*DIV);
    btn = 0; step(10);

    // R4: zero ms uses default 10 ms -> 120 ticks
    tag = "R4"; btn = 1; ms = 0; step(2); pulse_req(); wait_res(c, n);
    chk("R4 default hold code", c == 3, c, 3);
    chk("R4 default timing", n >= (lim_of(DEF_MS)-1)*DIV && n <= lim_of(DEF_MS)*DIV+3, n, lim_of(DEF_MS)*DIV);
    btn = 0; step(10);

    // R5: single click, window restarted at release
    tag = "R5"; ms = 3; btn = 1; step(2); pulse_req(); step(20); btn = 0;
    wait_res(c, n);
    chk("R5 single code", c == 1, c, 1);
    chk("R5 window from release", n >= (lim_of(GAP_MS)-1)*DIV && n <= lim_of(GAP_MS)*DIV+3, n, lim_of(GAP_MS)*DIV);
    step(10);

    // R6: double click
    tag = "R6"; btn = 1; step(2); pulse_req(); step(20); btn = 0; step(50); btn = 1;
    wait_res(c, n);
    chk("R6 double code", c == 2, c, 2);
    btn = 0; step(10);

    // R7: held-only early release, then held-only hold
    tag = "R7"; hold_only = 1; btn = 1; step(2); pulse_req(); step(15); btn = 0;
    wait_res(c, n);
    chk("R7 early release single", c == 1, c, 1);
    chk("R7 immediate result", n <= 1, n, 1);
    step(5); btn = 1; step(2); pulse_req(); wait_res(c, n);
    chk("R7 held-only hold", c == 3, c, 3);
    btn = 0; hold_only = 0; step(10);

    // R9: request while busy, carrying a different mode and limit
    tag = "R9"; btn = 1; ms = 3; step(2); pulse_req(); step(10);
    hold_only = 1; ms = 0; pulse_req(); hold_only = 0; ms = 3;
    wait_res(c, n);
    chk("R9 limit kept", c == 3 && n <= lim_of(3)*DIV, n, lim_of(3)*DIV - 11);
    btn = 0; step(10);

    // R10: 30 ms -> 360 ticks, truncated to 104 on an 8-bit counter
    tag = "R10"; btn = 1; ms = 30; step(2); pulse_req(); wait_res(c, n);
    chk("R10 truncated hold code", c == 3, c, 3);
    chk("R10 truncated timing", n >= (lim_of(30)-1)*DIV && n <= lim_of(30)*DIV+3, n, lim_of(30)*DIV);
    btn = 0; step(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule